// File: doc/BRIEF.md
# Floating-Point Widening Converter

This block turns an IEEE single-precision (32-bit) or double-precision (64-bit) operand into the 80-bit extended-precision form that a floating-point datapath uses for all of its internal work. Every operand has to be converted into this form before any computation can use it. The result packs a sign, a 15-bit exponent with a bias of 16383, and a 64-bit mantissa whose integer bit is stored explicitly. A second copy of the result, in its 96-bit memory image, is also provided. In that image 16 zero bits sit between the exponent and the mantissa, which keeps the value longword aligned.

A 2-bit format select tells the block how to read the operand. The block has one register stage. The caller presents an operand with `in_valid` set, and the converted value and its class flags appear one clock later with `out_valid` set. Denormal inputs are normalised into the wider exponent range with a leading-zero count. Zeros keep their sign. Infinities and NaNs map to the all-ones exponent, and a NaN keeps its payload. The class flags report zero, infinity, NaN and signalling NaN.

Top module: `fp_widen`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `ext_out`, `mem_out` and all four class flags are zero.
- R2: With `fmt_sel` = 2'b00 the block reads `operand[31:0]` as sign bit 31, 8-bit exponent bits 30..23 and 23-bit fraction bits 22..0, and ignores `operand[63:32]`. A normal value gives exponent e+16256 and mantissa {1, fraction, 40 zeros}.
- R3: With `fmt_sel` = 2'b01 the block reads sign bit 63, 11-bit exponent bits 62..52 and 52-bit fraction bits 51..0. A normal value gives exponent e+15360 and mantissa {1, fraction, 11 zeros}.
- R4: A denormal input (exponent zero, fraction nonzero) gives mantissa bit 63 = 1 and exponent 16383 − bias − z. Here z is the number of leading zeros in the fraction field and bias is 127 or 1023. The fraction is shifted left by z+1 places.
- R5: A zero input of either sign gives exponent 0 and mantissa 0 with the sign kept, and raises `is_zero`.
- R6: An infinity input gives exponent 0x7FFF and mantissa 0x8000_0000_0000_0000 with the sign kept, and raises `is_inf`.
- R7: A NaN input gives exponent 0x7FFF and mantissa {1, fraction, zero fill}, keeping sign and payload, and raises `is_nan`. `is_snan` is also raised when the fraction MSB is clear.
- R8: A `fmt_sel` of 2'b10 or 2'b11 gives an all-zero result with all class flags clear.
- R9: `mem_out` equals {sign, exponent, 16 zero bits, mantissa}, with the sign in bit 95, the exponent in bits 94..80 and the mantissa in bits 63..0.
- R10: Results appear one clock after the inputs are sampled, and `out_valid` is `in_valid` delayed by one clock.
- R11: At most one of `is_zero`, `is_inf` and `is_nan` is set, `is_snan` is never set without `is_nan`, and normal and denormal inputs raise no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand valid |
| fmt_sel | input | 2 | Input format: 00 single, 01 double, 1x reserved |
| operand | input | 64 | Input operand; a single occupies bits 31..0 |
| out_valid | output | 1 | Result valid |
| ext_out | output | 80 | Extended result: sign 79, exponent 78..64, mantissa 63..0 |
| mem_out | output | 96 | Memory image with 16 zero bits inserted at 79..64 |
| is_zero | output | 1 | Result is a signed zero |
| is_inf | output | 1 | Result is an infinity |
| is_nan | output | 1 | Result is a NaN |
| is_snan | output | 1 | Result is a signalling NaN |

## Verification
The bench targets the smallest and largest denormals of both formats, because a leading-zero count that is off by one leaves the mantissa MSB clear or skews the exponent by one. It sends both signs of zero, since a design that drops the sign flips `ext_out[79]`. It sends quiet and signalling NaNs that differ only in the fraction MSB, which catches an inverted or missing signalling flag and any loss of payload. Single operands carry random upper bits and reserved format codes are sent, so a wrong field slice or a missing reserved-code guard shows up as a mismatch against the behavioural model.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

   localparam int EXT_EW   = 15;
   localparam int EXT_MW   = 64;
   localparam int EXT_W    = 1 + EXT_EW + EXT_MW;
   localparam int PAD_W    = 16;
   localparam int MEM_W    = EXT_W + PAD_W;
   localparam int EXT_BIAS = (1 << (EXT_EW - 1)) - 1;

   typedef enum logic [1:0] {
      FMT_SGL  = 2'b00,
      FMT_DBL  = 2'b01,
      FMT_RSV2 = 2'b10,
      FMT_RSV3 = 2'b11
   } fpw_fmt_e;

   typedef struct packed {
      logic              sign;
      logic [EXT_EW-1:0] exp;
      logic [EXT_MW-1:0] man;
   } fpw_ext_t;

   typedef struct packed {
      logic zero;
      logic inf;
      logic nan;
      logic snan;
   } fpw_class_t;

endpackage

// File: rtl/fpw_lzc.sv
module fpw_lzc #(
   parameter int W  = 23,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] count
);

   always_comb begin
      count = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec[i]) count = CW'(W - 1 - i);
      end
   end

endmodule

// File: rtl/fpw_unpack.sv
module fpw_unpack
   import fpw_pkg::*;
#(
   parameter int EW = 8,
   parameter int FW = 23
) (
   input  logic [EW+FW:0] raw,
   output fpw_ext_t       res,
   output fpw_class_t     cls
);

   localparam int BIAS   = (1 << (EW - 1)) - 1;
   localparam int REBIAS = EXT_BIAS - BIAS;
   localparam int CW     = $clog2(FW + 1);
   localparam int FILL_N = EXT_MW - 1 - FW;
   localparam int FILL_D = EXT_MW - FW;

   logic          sgn;
   logic [EW-1:0] bexp;
   logic [FW-1:0] frac;
   logic [CW-1:0] lz;
   logic [FW-1:0] norm;

   assign sgn  = raw[EW+FW];
   assign bexp = raw[EW+FW-1:FW];
   assign frac = raw[FW-1:0];

   fpw_lzc #(.W(FW), .CW(CW)) lzc_i (
      .vec   (frac),
      .count (lz)
   );

   assign norm = frac << lz;

   always_comb begin
      res      = '0;
      cls      = '0;
      res.sign = sgn;
      if (bexp == '1) begin
         res.exp  = '1;
         res.man  = {1'b1, frac, {FILL_N{1'b0}}};
         cls.inf  = (frac == '0);
         cls.nan  = (frac != '0);
         cls.snan = (frac != '0) && !frac[FW-1];
      end else if (bexp == '0) begin
         if (frac == '0) begin
            cls.zero = 1'b1;
         end else begin
            res.exp = EXT_EW'(REBIAS) - EXT_EW'(lz);
            res.man = {norm, {FILL_D{1'b0}}};
         end
      end else begin
         res.exp = EXT_EW'(bexp) + EXT_EW'(REBIAS);
         res.man = {1'b1, frac, {FILL_N{1'b0}}};
      end
   end

endmodule

// File: rtl/fp_widen.sv
module fp_widen
   import fpw_pkg::*;
#(
   parameter int SGL_EW = 8,
   parameter int SGL_FW = 23,
   parameter int DBL_EW = 11,
   parameter int DBL_FW = 52,
   localparam int SGL_W = SGL_EW + SGL_FW + 1,
   localparam int OP_W  = DBL_EW + DBL_FW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       fmt_sel,
   input  logic [OP_W-1:0]  operand,
   output logic             out_valid,
   output logic [EXT_W-1:0] ext_out,
   output logic [MEM_W-1:0] mem_out,
   output logic             is_zero,
   output logic             is_inf,
   output logic             is_nan,
   output logic             is_snan
);

   if (SGL_W > OP_W) begin : g_bad_sgl_w
      $error("single operand wider than the operand port");
   end
   if (SGL_FW > EXT_MW - 2 || DBL_FW > EXT_MW - 2) begin : g_bad_fw
      $error("fraction does not fit below the explicit integer bit");
   end
   if (SGL_EW >= EXT_EW || DBL_EW >= EXT_EW) begin : g_bad_ew
      $error("input exponent must be narrower than the extended exponent");
   end

   fpw_ext_t   sgl_res, dbl_res, sel_res, res_q;
   fpw_class_t sgl_cls, dbl_cls, sel_cls, cls_q;
   logic       vld_q;

   fpw_unpack #(.EW(SGL_EW), .FW(SGL_FW)) sgl_i (
      .raw (operand[SGL_W-1:0]),
      .res (sgl_res),
      .cls (sgl_cls)
   );

   fpw_unpack #(.EW(DBL_EW), .FW(DBL_FW)) dbl_i (
      .raw (operand),
      .res (dbl_res),
      .cls (dbl_cls)
   );

   always_comb begin
      case (fpw_fmt_e'(fmt_sel))
         FMT_SGL: begin
            sel_res = sgl_res;
            sel_cls = sgl_cls;
         end
         FMT_DBL: begin
            sel_res = dbl_res;
            sel_cls = dbl_cls;
         end
         default: begin
            sel_res = '0;
            sel_cls = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         res_q <= '0;
         cls_q <= '0;
      end else begin
         vld_q <= in_valid;
         res_q <= sel_res;
         cls_q <= sel_cls;
      end
   end

   assign out_valid = vld_q;
   assign ext_out   = res_q;
   assign mem_out   = {res_q.sign, res_q.exp, {PAD_W{1'b0}}, res_q.man};
   assign is_zero   = cls_q.zero;
   assign is_inf    = cls_q.inf;
   assign is_nan    = cls_q.nan;
   assign is_snan   = cls_q.snan;

endmodule

// File: rtl/fpw_chk.sv
module fpw_chk
   import fpw_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             out_valid,
   input logic [EXT_W-1:0] ext_out,
   input logic             is_zero,
   input logic             is_inf,
   input logic             is_nan,
   input logic             is_snan
);

   logic [EXT_EW-1:0] x_exp;
   logic [EXT_MW-1:0] x_man;
   assign x_exp = ext_out[EXT_W-2 -: EXT_EW];
   assign x_man = ext_out[EXT_MW-1:0];

   // R10
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R10
   idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R11
   class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({is_zero, is_inf, is_nan}));

   // R7
   snan_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_snan |-> (is_nan && x_exp == '1 && !x_man[EXT_MW-2]));

   // R5
   zero_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_zero |-> (x_exp == '0 && x_man == '0));

   // R6
   inf_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_inf |-> (x_exp == '1 && x_man == {1'b1, {(EXT_MW-1){1'b0}}}));

   // R4
   norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x_exp != '0) |-> x_man[EXT_MW-1]);

endmodule

bind fp_widen fpw_chk chk_i (.*);

// File: tb/fp_widen_tb_top.sv
module fp_widen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [1:0]  fmt_sel;
   logic [63:0] operand;
   logic        out_valid;
   logic [79:0] ext_out;
   logic [95:0] mem_out;
   logic        is_zero, is_inf, is_nan, is_snan;

   int checks   = 0;
   int failures = 0;
   logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

   typedef struct {
      logic        v;
      logic [79:0] x;
      logic [3:0]  c;
      string       tag;
   } exp_t;

   exp_t q[$];

   always #10 clk = ~clk;

   fp_widen dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_sel(fmt_sel),
      .operand(operand), .out_valid(out_valid), .ext_out(ext_out),
      .mem_out(mem_out), .is_zero(is_zero), .is_inf(is_inf),
      .is_nan(is_nan), .is_snan(is_snan)
   );

   function automatic logic [83:0] ref_model(logic [1:0] f, logic [63:0] op);
      longint unsigned e, frac, m, emax, man;
      int fw, bias, ex;
      logic s, z, inf, nan, sn;
      if (f == 2'b00) begin
         s = op[31]; e = op[30:23]; frac = op[22:0]; fw = 23; bias = 127; emax = 255;
      end else if (f == 2'b01) begin
         s = op[63]; e = op[62:52]; frac = op[51:0]; fw = 52; bias = 1023; emax = 2047;
      end else begin
         return '0;
      end
      z = 0; inf = 0; nan = 0; sn = 0;
      if (e == emax) begin
         ex  = 32'h7FFF;
         man = (64'd1 << 63) | (frac << (63 - fw));
         inf = (frac == 0);
         nan = (frac != 0);
         sn  = nan && (((frac >> (fw - 1)) & 1) == 0);
      end else if (e == 0 && frac == 0) begin
         ex = 0; man = 0; z = 1;
      end else if (e == 0) begin
         ex = 16383 + 1 - bias;
         m  = frac;
         while (((m >> fw) & 1) == 0) begin
            m  = m << 1;
            ex = ex - 1;
         end
         man = m << (63 - fw);
      end else begin
         ex  = int'(e) - bias + 16383;
         man = ((64'd1 << fw) | frac) << (63 - fw);
      end
      return {s, ex[14:0], man, z, inf, nan, sn};
   endfunction

   task automatic check(bit ok, string tag, string what, logic [95:0] act, logic [95:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   task automatic compare(exp_t e);
      logic [95:0] mimg;
      check(out_valid == e.v, "R10", "out_valid", 96'(out_valid), 96'(e.v));
      if (e.v) begin
         mimg = {e.x[79:64], 16'h0, e.x[63:0]};
         check(ext_out == e.x, e.tag, "ext_out", 96'(ext_out), 96'(e.x));
         check(mem_out == mimg, "R9", "mem_out", mem_out, mimg);
         check({is_zero, is_inf, is_nan, is_snan} == e.c, "R11", "flags",
               96'({is_zero, is_inf, is_nan, is_snan}), 96'(e.c));
      end
   endtask

   task automatic apply(logic v, logic [1:0] f, logic [63:0] op, string tag);
      logic [83:0] r;
      exp_t e;
      @(negedge clk);
      if (q.size() > 0) compare(q.pop_front());
      in_valid = v; fmt_sel = f; operand = op;
      r = ref_model(f, op);
      e.v = v; e.x = r[83:4]; e.c = r[3:0]; e.tag = tag;
      q.push_back(e);
   endtask

   function automatic logic [63:0] next_rand();
      seed ^= seed << 13;
      seed ^= seed >> 7;
      seed ^= seed << 17;
      return seed;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [63:0] r;
      rst_n = 1'b0; in_valid = 1'b1; fmt_sel = 2'b00; operand = 64'h3F80_0000;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(out_valid == 0, "R1", "out_valid", 96'(out_valid), 96'd0);
      check(ext_out == 0, "R1", "ext_out", 96'(ext_out), 96'd0);
      check(mem_out == 0, "R1", "mem_out", mem_out, 96'd0);
      check({is_zero, is_inf, is_nan, is_snan} == 0, "R1", "flags",
            96'({is_zero, is_inf, is_nan, is_snan}), 96'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R2 single normals, upper bits must be ignored
      apply(1, 2'b00, 64'h0000_0000_3F80_0000, "R2");
      apply(1, 2'b00, 64'hDEAD_BEEF_C020_0000, "R2");
      apply(1, 2'b00, 64'h0000_0000_7F7F_FFFF, "R2");
      apply(1, 2'b00, 64'h0000_0000_0080_0000, "R2");
      // R3 double normals
      apply(1, 2'b01, 64'h3FF0_0000_0000_0000, "R3");
      apply(1, 2'b01, 64'hC009_21FB_5444_2D18, "R3");
      apply(1, 2'b01, 64'h7FEF_FFFF_FFFF_FFFF, "R3");
      apply(1, 2'b01, 64'h0010_0000_0000_0000, "R3");
      // R4 denormals
      apply(1, 2'b00, 64'h0000_0000_0000_0001, "R4");
      apply(1, 2'b00, 64'h0000_0000_807F_FFFF, "R4");
      apply(1, 2'b00, 64'h0000_0000_0040_0000, "R4");
      apply(1, 2'b01, 64'h0000_0000_0000_0001, "R4");
      apply(1, 2'b01, 64'h800F_FFFF_FFFF_FFFF, "R4");
      // R5 signed zeros
      apply(1, 2'b00, 64'h0000_0000_0000_0000, "R5");
      apply(1, 2'b00, 64'hFFFF_FFFF_8000_0000, "R5");
      apply(1, 2'b01, 64'h8000_0000_0000_0000, "R5");
      // R6 infinities
      apply(1, 2'b00, 64'h0000_0000_FF80_0000, "R6");
      apply(1, 2'b01, 64'h7FF0_0000_0000_0000, "R6");
      // R7 quiet and signalling NaNs
      apply(1, 2'b00, 64'h0000_0000_7FC0_0001, "R7");
      apply(1, 2'b00, 64'h0000_0000_FF80_0001, "R7");
      apply(1, 2'b01, 64'h7FF8_0000_0000_0000, "R7");
      apply(1, 2'b01, 64'hFFF0_0000_0000_0ABC, "R7");
      // R8 reserved format codes
      apply(1, 2'b10, 64'h3FF0_0000_0000_0000, "R8");
      apply(1, 2'b11, 64'h7FF0_0000_0000_0001, "R8");
      // R10 idle gaps
      apply(0, 2'b00, 64'h0, "R10");
      apply(1, 2'b01, 64'h4000_0000_0000_0000, "R10");
      apply(0, 2'b01, 64'h1234_5678_9ABC_DEF0, "R10");

      for (int i = 0; i < 400; i++) begin
         r = next_rand();
         case (r[3:2])
            2'b00: r[62:52] = '0;
            2'b01: r[62:52] = '1;
            default: ;
         endcase
         if (r[1]) r[30:23] = r[0] ? 8'hFF : 8'h00;
         if (i % 2 == 0) apply(1, 2'b00, r, "R2");
         else            apply(1, 2'b01, r, "R3");
      end

      apply(0, 2'b00, 64'h0, "R10");
      @(negedge clk);
      while (q.size() > 0) compare(q.pop_front());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule